// File: doc/BRIEF.md
# Prioritized Interrupt Request Unit

This block gathers five interrupt request sources for a small processor and tells the core, every cycle, which request it should take next. The sources are one request line that no mask can silence, three single-pin vectored lines with individual masks, and one general request line. A general request has no fixed service address: the core must fetch an opcode from outside logic during the acknowledge.

The controller programs the three line masks with a write strobe and a data word. The same write can also discard a pending capture on the edge-triggered line. A global enable is set and cleared by separate strobes. A status word always shows the masks, the global enable and the three pending bits. When the core takes the presented request, it pulses the acknowledge input. This clears the source that was serviced and drops the global enable, so software has to enable interrupts again before any further maskable request is presented.

The unprotected reset input is released through a two-stage synchronizer. All state then leaves reset two clock edges after the reset input rises.

Top module: `irq_prio_unit`

## Requirements
- R1: An accepted non-maskable request is presented (`irq_valid_o`=1, `irq_src_o`=1) whatever the three masks and the global enable hold.
- R2: Fixed priority, highest first: non-maskable (src 1), line A (src 2), line B (src 3), line C (src 4), general (src 5). `irq_src_o`=0 when nothing is presented. A maskable source needs the global enable set and its mask bit clear.
- R3: The vector output is 8'h24 for the non-maskable source, 8'h3C for A, 8'h34 for B and 8'h2C for C. For the general source it is 8'h00 and `irq_ext_op_o`=1. Otherwise `irq_ext_op_o`=0.
- R4: When `mask_wr_i` is high at a clock edge, the masks take `mask_wdata_i` from that edge on (bit 0 = A, bit 1 = B, bit 2 = C, 1 = masked). A masked line is never presented, but its pending bit still shows.
- R5: A rising edge on line A sets a latch. The latch holds after the line falls, until A is acknowledged or a mask write is made with `mask_clr_a_i`=1. An edge in the same cycle as the clear wins.
- R6: Lines B, C and general are level sensitive. Once the input falls, the line is no longer presented.
- R7: The non-maskable line is accepted in the cycle after a rising edge, and only while it stays high. If it falls before the acknowledge, the request is withdrawn. After an acknowledge it is not presented again until it has gone low and risen again.
- R8: Acknowledging a presented request clears the global enable, and this clear wins over `en_set_i`. `en_set_i` sets the enable and `en_clr_i` clears it.
- R9: `status_o` holds the masks in [2:0], the global enable in [3], the line A latch in [4], and the raw levels of lines B and C in [5] and [6].
- R10: After reset the masks are all 1, the global enable is 0, the line A latch is clear and no request is presented.
- R11: An acknowledge while nothing is presented changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| nmi_in | input | 1 | Non-maskable request line |
| line_a_in | input | 1 | Edge-triggered vectored line A |
| line_b_in | input | 1 | Level vectored line B |
| line_c_in | input | 1 | Level vectored line C |
| gen_in | input | 1 | General request line (external opcode) |
| ack_i | input | 1 | Acknowledge of the presented request |
| en_set_i | input | 1 | Set global enable |
| en_clr_i | input | 1 | Clear global enable |
| mask_wr_i | input | 1 | Mask write strobe |
| mask_wdata_i | input | 3 | New masks, bit 0 = A |
| mask_clr_a_i | input | 1 | With mask write: discard line A latch |
| irq_valid_o | output | 1 | A request is presented |
| irq_src_o | output | 3 | Presented source code |
| irq_vector_o | output | 8 | Service address of presented source |
| irq_ext_op_o | output | 1 | Opcode must come from outside logic |
| status_o | output | 7 | Masks, enable, pending bits |

## Verification
The assertions assume that all request lines and strobes are synchronous to `clk` and stable around its rising edge. They also assume that `ack_i` is only meaningful in a cycle where the core has seen `irq_valid_o`. The bench drives every input just after the falling edge, so each value is settled long before the next rising edge. Its random phase issues acknowledges freely, including when nothing is presented, because that case is defined to have no effect. The non-maskable line is toggled at random, so it often rises and falls again before any acknowledge arrives.

// File: rtl/irq_prio_pkg.sv
package irq_prio_pkg;
  localparam int NUM_VEC  = 3;             // maskable vectored lines A, B, C
  localparam int NUM_SRC  = NUM_VEC + 2;   // plus non-maskable and general
  localparam int SRC_W    = 3;
  localparam int STAT_W   = 2 * NUM_VEC + 1;

  typedef enum logic [SRC_W-1:0] {
    SRC_NONE = 3'd0,
    SRC_NMI  = 3'd1,
    SRC_A    = 3'd2,
    SRC_B    = 3'd3,
    SRC_C    = 3'd4,
    SRC_GEN  = 3'd5
  } irq_src_e;
endpackage

// File: rtl/irq_edge_catch.sv
// Rising-edge capture. NEED_HOLD selects the variant whose capture is only
// valid while the input stays high (and drops when it falls).
module irq_edge_catch #(
  parameter bit NEED_HOLD = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req_i,
  input  logic clr_i,
  output logic pend_o
);
  logic prev_q, flag_q, flag_d, rise;

  assign rise = req_i & ~prev_q;

  if (NEED_HOLD) begin : g_hold
    always_comb flag_d = rise | (flag_q & req_i & ~clr_i);
    assign pend_o = flag_q & req_i;
  end else begin : g_latch
    always_comb flag_d = rise | (flag_q & ~clr_i);
    assign pend_o = flag_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      prev_q <= req_i;
      flag_q <= flag_d;
    end
  end
endmodule

// File: rtl/irq_prio_pick.sv
// Fixed-priority picker: index 0 is the most urgent.
module irq_prio_pick #(
  parameter int N = 5
) (
  input  logic [N-1:0] req_i,
  output logic [N-1:0] gnt_o,
  output logic         any_o
);
  logic [N:0] blocked;

  assign blocked[0] = 1'b0;

  for (genvar i = 0; i < N; i++) begin : g_chain
    assign gnt_o[i]     = req_i[i] & ~blocked[i];
    assign blocked[i+1] = blocked[i] | req_i[i];
  end

  assign any_o = blocked[N];
endmodule

// File: rtl/irq_prio_unit.sv
module irq_prio_unit
  import irq_prio_pkg::*;
#(
  parameter logic [7:0] VEC_NMI = 8'h24,
  parameter logic [7:0] VEC_A   = 8'h3C,
  parameter logic [7:0] VEC_B   = 8'h34,
  parameter logic [7:0] VEC_C   = 8'h2C
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              nmi_in,
  input  logic              line_a_in,
  input  logic              line_b_in,
  input  logic              line_c_in,
  input  logic              gen_in,
  input  logic              ack_i,
  input  logic              en_set_i,
  input  logic              en_clr_i,
  input  logic              mask_wr_i,
  input  logic [NUM_VEC-1:0] mask_wdata_i,
  input  logic              mask_clr_a_i,
  output logic              irq_valid_o,
  output logic [SRC_W-1:0]  irq_src_o,
  output logic [7:0]        irq_vector_o,
  output logic              irq_ext_op_o,
  output logic [STAT_W-1:0] status_o
);
  // reset: asynchronous assert, synchronous release
  logic rst_meta_q, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  logic [NUM_SRC-1:0] elig, gnt;
  logic               any_req, accept;
  logic               nmi_pend, a_pend;
  logic               clr_nmi, clr_a;
  logic [NUM_VEC-1:0] mask_q, mask_d;
  logic [NUM_VEC-1:0] vec_pend;
  logic               gie_q, gie_d;
  irq_src_e           src;

  assign accept  = ack_i & any_req;
  assign clr_nmi = accept & gnt[0];
  assign clr_a   = (accept & gnt[1]) | (mask_wr_i & mask_clr_a_i);

  irq_edge_catch #(.NEED_HOLD(1'b1)) u_nmi_catch (
    .clk(clk), .rst_n(rst_sync_n), .req_i(nmi_in), .clr_i(clr_nmi), .pend_o(nmi_pend)
  );

  irq_edge_catch #(.NEED_HOLD(1'b0)) u_a_catch (
    .clk(clk), .rst_n(rst_sync_n), .req_i(line_a_in), .clr_i(clr_a), .pend_o(a_pend)
  );

  assign vec_pend = {line_c_in, line_b_in, a_pend};

  // per-line mask registers
  for (genvar i = 0; i < NUM_VEC; i++) begin : g_mask
    always_comb mask_d[i] = mask_wr_i ? mask_wdata_i[i] : mask_q[i];
    always_ff @(posedge clk or negedge rst_sync_n) begin
      if (!rst_sync_n) mask_q[i] <= 1'b1;
      else             mask_q[i] <= mask_d[i];
    end
    assign elig[i+1] = vec_pend[i] & ~mask_q[i] & gie_q;
  end

  assign elig[0]         = nmi_pend;
  assign elig[NUM_SRC-1] = gen_in & gie_q;

  // global enable: clearing wins
  always_comb begin
    gie_d = gie_q;
    if (en_set_i)           gie_d = 1'b1;
    if (en_clr_i || accept) gie_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) gie_q <= 1'b0;
    else             gie_q <= gie_d;
  end

  irq_prio_pick #(.N(NUM_SRC)) u_pick (
    .req_i(elig), .gnt_o(gnt), .any_o(any_req)
  );

  always_comb begin
    src          = SRC_NONE;
    irq_vector_o = 8'h00;
    irq_ext_op_o = 1'b0;
    unique case (1'b1)
      gnt[0]: begin src = SRC_NMI; irq_vector_o = VEC_NMI; end
      gnt[1]: begin src = SRC_A;   irq_vector_o = VEC_A;   end
      gnt[2]: begin src = SRC_B;   irq_vector_o = VEC_B;   end
      gnt[3]: begin src = SRC_C;   irq_vector_o = VEC_C;   end
      gnt[4]: begin src = SRC_GEN; irq_ext_op_o = 1'b1;    end
      default: ;
    endcase
  end

  assign irq_valid_o = any_req;
  assign irq_src_o   = src;
  assign status_o    = {vec_pend, gie_q, mask_q};
endmodule

// File: rtl/irq_prio_unit_chk.sv
module irq_prio_unit_chk
  import irq_prio_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              nmi_pend,
  input logic              line_b_in,
  input logic              ack_i,
  input logic              mask_wr_i,
  input logic [NUM_VEC-1:0] mask_wdata_i,
  input logic              mask_clr_a_i,
  input logic              irq_valid_o,
  input logic [SRC_W-1:0]  irq_src_o,
  input logic [7:0]        irq_vector_o,
  input logic [STAT_W-1:0] status_o
);
  assert_nmi_unmaskable_R1: assert property (@(posedge clk) disable iff (!rst_n)
    nmi_pend |-> (irq_valid_o && irq_src_o == SRC_NMI));

  assert_b_beats_c_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_valid_o && irq_src_o == SRC_C) |-> !(line_b_in && !status_o[1] && status_o[3]));

  assert_gen_below_nmi_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_src_o == SRC_GEN) |-> !nmi_pend);

  assert_vec_a_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_valid_o && irq_src_o == SRC_A) |-> irq_vector_o == 8'h3C);

  assert_mask_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
    mask_wr_i |=> status_o[2:0] == $past(mask_wdata_i));

  assert_a_holds_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (status_o[4] && !(ack_i && irq_valid_o && irq_src_o == SRC_A)
                 && !(mask_wr_i && mask_clr_a_i)) |=> status_o[4]);

  assert_nmi_once_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_i && irq_valid_o && irq_src_o == SRC_NMI) |=> !nmi_pend);

  assert_ack_drops_enable_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_i && irq_valid_o) |=> !status_o[3]);
endmodule

bind irq_prio_unit irq_prio_unit_chk u_chk (
  .clk(clk), .rst_n(rst_sync_n), .nmi_pend(nmi_pend), .line_b_in(line_b_in),
  .ack_i(ack_i), .mask_wr_i(mask_wr_i), .mask_wdata_i(mask_wdata_i),
  .mask_clr_a_i(mask_clr_a_i), .irq_valid_o(irq_valid_o), .irq_src_o(irq_src_o),
  .irq_vector_o(irq_vector_o), .status_o(status_o)
);

// File: tb/irq_prio_unit_bench.sv
module irq_prio_unit_bench;
  timeunit 1ns;
  timeprecision 1ps;

  logic clk, rst_n;
  logic nmi_in, line_a_in, line_b_in, line_c_in, gen_in;
  logic ack_i, en_set_i, en_clr_i, mask_wr_i, mask_clr_a_i;
  logic [2:0] mask_wdata_i;
  logic irq_valid_o, irq_ext_op_o;
  logic [2:0] irq_src_o;
  logic [7:0] irq_vector_o;
  logic [6:0] status_o;

  int checks = 0;
  int errors = 0;

  irq_prio_unit u_irq_prio_unit (
    .clk(clk), .rst_n(rst_n), .nmi_in(nmi_in), .line_a_in(line_a_in),
    .line_b_in(line_b_in), .line_c_in(line_c_in), .gen_in(gen_in),
    .ack_i(ack_i), .en_set_i(en_set_i), .en_clr_i(en_clr_i),
    .mask_wr_i(mask_wr_i), .mask_wdata_i(mask_wdata_i), .mask_clr_a_i(mask_clr_a_i),
    .irq_valid_o(irq_valid_o), .irq_src_o(irq_src_o), .irq_vector_o(irq_vector_o),
    .irq_ext_op_o(irq_ext_op_o), .status_o(status_o)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // behavioural reference state
  bit m_mask[3];
  bit m_gie, m_a, m_nseen, m_aprev, m_nprev;
  int e_src;
  int e_vec;

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic void model_reset();
    foreach (m_mask[i]) m_mask[i] = 1'b1;
    m_gie = 0; m_a = 0; m_nseen = 0; m_aprev = 0; m_nprev = 0;
  endfunction

  function automatic void model_pick();
    e_src = 0; e_vec = 0;
    if (m_nseen && nmi_in)                     begin e_src = 1; e_vec = 'h24; end
    else if (m_gie && m_a && !m_mask[0])       begin e_src = 2; e_vec = 'h3C; end
    else if (m_gie && line_b_in && !m_mask[1]) begin e_src = 3; e_vec = 'h34; end
    else if (m_gie && line_c_in && !m_mask[2]) begin e_src = 4; e_vec = 'h2C; end
    else if (m_gie && gen_in)                  begin e_src = 5; e_vec = 0; end
  endfunction

  function automatic void model_step();
    bit acc;
    model_pick();
    acc = ack_i && (e_src != 0);
    m_nseen = (nmi_in && !m_nprev) || (m_nseen && nmi_in && !(acc && e_src == 1));
    m_a = (line_a_in && !m_aprev) ||
          (m_a && !((acc && e_src == 2) || (mask_wr_i && mask_clr_a_i)));
    if (mask_wr_i) foreach (m_mask[i]) m_mask[i] = mask_wdata_i[i];
    if (en_set_i) m_gie = 1;
    if (en_clr_i || acc) m_gie = 0;
    m_nprev = nmi_in;
    m_aprev = line_a_in;
  endfunction

  task automatic compare_all();
    model_pick();
    check("R2 valid", int'(irq_valid_o), int'(e_src != 0));
    check("R2 src", int'(irq_src_o), e_src);
    check("R3 vector", int'(irq_vector_o), e_vec);
    check("R3 ext_op", int'(irq_ext_op_o), int'(e_src == 5));
    check("R9 status", int'(status_o),
          int'({line_c_in, line_b_in, m_a, m_gie, m_mask[2], m_mask[1], m_mask[0]}));
  endtask

  task automatic tick();
    @(posedge clk);
    model_step();
    @(negedge clk);
    compare_all();
  endtask

  task automatic strobes_off();
    ack_i = 0; en_set_i = 0; en_clr_i = 0; mask_wr_i = 0; mask_clr_a_i = 0;
  endtask

  initial begin
    #(5.0 * 150000);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 0;
    nmi_in = 0; line_a_in = 0; line_b_in = 0; line_c_in = 0; gen_in = 0;
    mask_wdata_i = 0;
    strobes_off();
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) tick();

    // R10 reset state
    check("R10 status", int'(status_o), 'b000_0_111);
    check("R10 valid", int'(irq_valid_o), 0);

    // general request needs enable; R8 and R3
    gen_in = 1; tick();
    check("R8 no enable", int'(irq_valid_o), 0);
    en_set_i = 1; tick(); en_set_i = 0;
    check("R3 gen src", int'(irq_src_o), 5);
    check("R3 gen ext", int'(irq_ext_op_o), 1);
    ack_i = 1; tick(); ack_i = 0;
    check("R8 ack clears", int'(status_o[3]), 0);
    check("R8 not presented", int'(irq_valid_o), 0);
    gen_in = 0;

    // B over C, levels (R2, R6)
    mask_wr_i = 1; mask_wdata_i = 3'b000; tick(); mask_wr_i = 0;
    en_set_i = 1; tick(); en_set_i = 0;
    line_b_in = 1; line_c_in = 1; tick();
    check("R2 B first", int'(irq_src_o), 3);
    line_b_in = 0; tick();
    check("R6 C after B drop", int'(irq_src_o), 4);
    check("R3 C vector", int'(irq_vector_o), 'h2C);
    line_c_in = 0; tick();
    check("R6 C dropped", int'(irq_valid_o), 0);

    // line A latch (R5)
    line_a_in = 1; tick(); line_a_in = 0; tick();
    check("R5 A held", int'(irq_src_o), 2);
    check("R5 A pending", int'(status_o[4]), 1);
    ack_i = 1; tick(); ack_i = 0;
    check("R5 A serviced", int'(status_o[4]), 0);

    // masked A still pending, cleared by mask write (R4, R5)
    mask_wr_i = 1; mask_wdata_i = 3'b001; en_set_i = 1; tick(); strobes_off();
    line_a_in = 1; tick(); line_a_in = 0; tick();
    check("R4 masked not presented", int'(irq_valid_o), 0);
    check("R4 pending visible", int'(status_o[4]), 1);
    mask_wr_i = 1; mask_clr_a_i = 1; tick(); strobes_off();
    check("R5 cleared by write", int'(status_o[4]), 0);

    // non-maskable (R1, R7)
    en_clr_i = 1; mask_wr_i = 1; mask_wdata_i = 3'b111; tick(); strobes_off();
    nmi_in = 1; tick();
    check("R1 nmi presented", int'(irq_src_o), 1);
    check("R1 nmi vector", int'(irq_vector_o), 'h24);
    ack_i = 1; tick(); ack_i = 0;
    check("R7 no repeat", int'(irq_valid_o), 0);
    tick();
    check("R7 still none", int'(irq_valid_o), 0);
    nmi_in = 0; tick(); nmi_in = 1; tick();
    check("R7 rearmed", int'(irq_src_o), 1);
    nmi_in = 0; tick();
    check("R7 withdrawn", int'(irq_valid_o), 0);

    // ack with nothing presented (R11)
    en_set_i = 1; tick(); en_set_i = 0;
    ack_i = 1; tick(); ack_i = 0;
    check("R11 enable kept", int'(status_o[3]), 1);

    // full priority walk (R2)
    mask_wr_i = 1; mask_wdata_i = 3'b000; tick(); mask_wr_i = 0;
    nmi_in = 1; line_a_in = 1; line_b_in = 1; line_c_in = 1; gen_in = 1; tick();
    check("R2 nmi top", int'(irq_src_o), 1);
    ack_i = 1; tick(); ack_i = 0;
    en_set_i = 1; tick(); en_set_i = 0;
    check("R2 A next", int'(irq_src_o), 2);
    ack_i = 1; tick(); ack_i = 0;
    en_set_i = 1; tick(); en_set_i = 0;
    check("R2 B next", int'(irq_src_o), 3);
    nmi_in = 0; line_a_in = 0; line_b_in = 0; line_c_in = 0; gen_in = 0;
    tick();

    // random phase, reference compared every cycle
    for (int n = 0; n < 4000; n++) begin
      nmi_in    = ($urandom_range(0, 5) == 0) ? ~nmi_in : nmi_in;
      line_a_in = $urandom_range(0, 3) == 0;
      line_b_in = $urandom_range(0, 3) == 0;
      line_c_in = $urandom_range(0, 3) == 0;
      gen_in    = $urandom_range(0, 2) == 0;
      ack_i     = $urandom_range(0, 2) == 0;
      en_set_i  = $urandom_range(0, 2) == 0;
      en_clr_i  = $urandom_range(0, 9) == 0;
      mask_wr_i = $urandom_range(0, 7) == 0;
      mask_wdata_i = 3'($urandom_range(0, 7));
      mask_clr_a_i = $urandom_range(0, 1) == 1;
      tick();
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule